// File: doc/BRIEF.md
# Flash Self-Write Controller

This block lets a processor erase and reprogram its own program store. The processor writes byte-wide registers to set up a transaction. It loads an address, a 14-bit data word and a control byte, and it writes a two-value key. The key gates every modifying operation. An internal array of 14-bit words stands in for the flash and can be read combinationally.

Each row holds `LATCHES` words. A row erase sets every word of the row to 0x3FFF. To program, the processor first stages words into per-row write latches, with no effect on the array. It then commits the whole latch block into one row. Programming can only clear bits, so a target word must already be erased.

During an erase or a commit, the block raises a CPU stall for a fixed number of cycles. The stall begins after a two-cycle setup window. The clock keeps running throughout.

Register selects (`reg_sel`):

| Code | Register |
|------|----------|
| 0 | Address, low byte |
| 1 | Address, high byte |
| 2 | Data, low byte |
| 3 | Data, bits 13:8, taken from the low six bits of `reg_wdata` |
| 4 | Control |
| 5 | Key |

Control bits:

| Bit | Name | Meaning |
|-----|------|---------|
| 0 | start | Begin an operation |
| 1 | enable | Write enable |
| 2 | erase | Row erase |
| 3 | latch-only | Stage into the latches without touching the array |
| 4 | alt-space | Selects the other memory space |

Top module: `flash_selfwrite_ctrl`

## Requirements
- R1: A control write (select 4) with bit 0 set starts an operation only if it directly follows a key write (select 5) of 0x55 and then a key write of 0x AA, with no other register write in between. Otherwise the operation is ignored, `err_flag` goes high, and `wr_busy` stays low.
- R2: `err_flag` is 0 after reset and returns to 0 when a later start is accepted.
- R3: An erase (control bits 0, 1 and 2 set) sets all `LATCHES` words of the row given by the upper address bits to 0x3FFF. The low address bits are ignored, and other rows are not touched.
- R4: After an accepted erase or commit, `wr_busy` is high and `cpu_stall` is low for two cycles. `cpu_stall` is then high for exactly `ERASE_CYCLES` or `PROG_CYCLES` cycles. After that, both fall together.
- R5: `free_flag` (control bit 2) stays high during the erase stall and is 0 once the erase finishes.
- R6: With control bit 3 set and bit 2 clear, an unlocked start copies the data word into the latch picked by the low address bits. There is no stall, `wr_busy` stays low, and the array is unchanged.
- R7: With control bits 2 and 3 clear, an unlocked start loads the final latch and writes every latch into the addressed row only. Latches that were never loaded hold 0x3FFF and leave their words unchanged.
- R8: After a commit, every latch holds 0x3FFF again.
- R9: Programming stores the bitwise AND of the old word and the latch value. There is no automatic erase.
- R10: An unlocked start with control bit 1 clear, or with bit 4 set, has no effect: no stall, `wr_busy` stays low, and the array is unchanged.
- R11: After reset, every array word is 0x3FFF, and `cpu_stall`, `wr_busy`, `free_flag` and `err_flag` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select |
| reg_wdata | input | 8 | Register write data |
| rd_addr | input | ADDR_W | Array read address |
| rd_word | output | 14 | Array word at `rd_addr` |
| cpu_stall | output | 1 | Processor stall |
| wr_busy | output | 1 | Operation in progress (start bit readback) |
| free_flag | output | 1 | Erase-select bit readback |
| err_flag | output | 1 | Start seen without a valid unlock |

## Verification
The bench breaks the key sequence in two ways: with a non-key write between the two key values, and with a wrong key value between them. A controller that tracks only the last key value would start an operation here instead of flagging it. The bench counts the setup and stall cycles exactly, which catches a missing setup window or a stall that is off by one. It commits with a single loaded latch after an erase, so latches that are not reset to all-ones would bring back stale data. It also reprograms a word that has not been erased, which exposes a store that overwrites instead of AND-ing. Finally, it checks the word just past the row, which would change if a commit or erase spilled across the row boundary.

// File: rtl/fsw_pkg.sv
package fsw_pkg;
    localparam int WORD_W = 14;
    localparam logic [WORD_W-1:0] ERASED = 14'h3FFF;

    localparam logic [2:0] SEL_ADDR_LO = 3'd0;
    localparam logic [2:0] SEL_ADDR_HI = 3'd1;
    localparam logic [2:0] SEL_DATA_LO = 3'd2;
    localparam logic [2:0] SEL_DATA_HI = 3'd3;
    localparam logic [2:0] SEL_CTRL    = 3'd4;
    localparam logic [2:0] SEL_KEY     = 3'd5;

    localparam int CB_START = 0;
    localparam int CB_EN    = 1;
    localparam int CB_ERASE = 2;
    localparam int CB_LATCH = 3;
    localparam int CB_ALT   = 4;

    localparam logic [7:0] KEY_FIRST  = 8'h55;
    localparam logic [7:0] KEY_SECOND = 8'hAA;

    typedef enum logic [1:0] {PH_IDLE, PH_SETUP, PH_BUSY} phase_t;
    typedef enum logic [1:0] {KS_NONE, KS_HALF, KS_ARMED} key_t;
endpackage

// File: rtl/fsw_key_unlock.sv
module fsw_key_unlock
    import fsw_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       we,
    input  logic [2:0] sel,
    input  logic [7:0] wdata,
    output logic       armed
);
    key_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we) begin
            if (sel == SEL_KEY && wdata == KEY_FIRST)
                st_d = KS_HALF;
            else if (sel == SEL_KEY && wdata == KEY_SECOND && st_q == KS_HALF)
                st_d = KS_ARMED;
            else
                st_d = KS_NONE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= KS_NONE;
        else        st_q <= st_d;
    end

    assign armed = (st_q == KS_ARMED);
endmodule

// File: rtl/fsw_word_array.sv
module fsw_word_array
    import fsw_pkg::*;
#(
    parameter int ADDR_W  = 9,
    parameter int LATCHES = 8
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           erase_en,
    input  logic                           prog_en,
    input  logic [ADDR_W-$clog2(LATCHES)-1:0] row,
    input  logic [LATCHES-1:0][WORD_W-1:0] prog_data,
    input  logic [ADDR_W-1:0]              rd_addr,
    output logic [WORD_W-1:0]              rd_data
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int LAT_W = $clog2(LATCHES);

    logic [WORD_W-1:0] mem_d [DEPTH];
    logic [WORD_W-1:0] mem_q [DEPTH];

    always_comb begin
        mem_d = mem_q;
        for (int i = 0; i < LATCHES; i++) begin
            logic [ADDR_W-1:0] idx;
            idx = {row, i[LAT_W-1:0]};
            if (erase_en)
                mem_d[idx] = ERASED;
            else if (prog_en)
                mem_d[idx] = mem_q[idx] & prog_data[i];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) mem_q <= '{default: ERASED};
        else        mem_q <= mem_d;
    end

    assign rd_data = mem_q[rd_addr];
endmodule

// File: rtl/flash_selfwrite_ctrl.sv
module flash_selfwrite_ctrl
    import fsw_pkg::*;
#(
    parameter int ADDR_W       = 9,
    parameter int LATCHES      = 8,
    parameter int ERASE_CYCLES = 64,
    parameter int PROG_CYCLES  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [2:0]        reg_sel,
    input  logic [7:0]        reg_wdata,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [13:0]       rd_word,
    output logic              cpu_stall,
    output logic              wr_busy,
    output logic              free_flag,
    output logic              err_flag
);
    localparam int LAT_W = $clog2(LATCHES);
    localparam int ROW_W = ADDR_W - LAT_W;
    localparam int MAXC  = (ERASE_CYCLES > PROG_CYCLES) ? ERASE_CYCLES : PROG_CYCLES;
    localparam int CNT_W = $clog2(MAXC + 1);

    typedef struct packed {
        phase_t                          phase;
        logic                            op_erase;
        logic [CNT_W-1:0]                cnt;
        logic [ADDR_W-1:0]               addr;
        logic [WORD_W-1:0]               data;
        logic                            en;
        logic                            erase;
        logic                            latch_only;
        logic                            alt;
        logic                            busy;
        logic                            err;
        logic [LATCHES-1:0][WORD_W-1:0]  lat;
    } st_t;

    st_t s_d, s_q;
    logic we_ok, key_armed, erase_go, prog_go;
    logic [CNT_W-1:0] last_cnt;

    assign we_ok = reg_we && (s_q.phase == PH_IDLE);

    fsw_key_unlock u_key (
        .clk(clk), .rst_n(rst_n), .we(we_ok),
        .sel(reg_sel), .wdata(reg_wdata), .armed(key_armed)
    );

    fsw_word_array #(.ADDR_W(ADDR_W), .LATCHES(LATCHES)) u_arr (
        .clk(clk), .rst_n(rst_n),
        .erase_en(erase_go), .prog_en(prog_go),
        .row(s_q.addr[ADDR_W-1:LAT_W]), .prog_data(s_q.lat),
        .rd_addr(rd_addr), .rd_data(rd_word)
    );

    assign last_cnt = s_q.op_erase ? CNT_W'(ERASE_CYCLES - 1) : CNT_W'(PROG_CYCLES - 1);

    always_comb begin
        s_d      = s_q;
        erase_go = 1'b0;
        prog_go  = 1'b0;
        unique case (s_q.phase)
            PH_IDLE: begin
                if (we_ok) begin
                    unique case (reg_sel)
                        SEL_ADDR_LO: s_d.addr[7:0] = reg_wdata;
                        SEL_ADDR_HI: s_d.addr = ADDR_W'({reg_wdata, s_q.addr[7:0]});
                        SEL_DATA_LO: s_d.data[7:0] = reg_wdata;
                        SEL_DATA_HI: s_d.data[13:8] = reg_wdata[5:0];
                        SEL_CTRL: begin
                            s_d.en         = reg_wdata[CB_EN];
                            s_d.erase      = reg_wdata[CB_ERASE];
                            s_d.latch_only = reg_wdata[CB_LATCH];
                            s_d.alt        = reg_wdata[CB_ALT];
                            if (reg_wdata[CB_START]) begin
                                if (!key_armed) begin
                                    s_d.err = 1'b1;
                                end else if (reg_wdata[CB_EN] && !reg_wdata[CB_ALT]) begin
                                    s_d.err = 1'b0;
                                    if (reg_wdata[CB_ERASE]) begin
                                        s_d.op_erase = 1'b1;
                                        s_d.phase    = PH_SETUP;
                                        s_d.cnt      = '0;
                                        s_d.busy     = 1'b1;
                                    end else begin
                                        s_d.lat[s_q.addr[LAT_W-1:0]] = s_q.data;
                                        if (!reg_wdata[CB_LATCH]) begin
                                            s_d.op_erase = 1'b0;
                                            s_d.phase    = PH_SETUP;
                                            s_d.cnt      = '0;
                                            s_d.busy     = 1'b1;
                                        end
                                    end
                                end
                            end
                        end
                        default: ;
                    endcase
                end
            end
            PH_SETUP: begin
                if (s_q.cnt == CNT_W'(1)) begin
                    s_d.phase = PH_BUSY;
                    s_d.cnt   = '0;
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
            PH_BUSY: begin
                if (s_q.cnt == last_cnt) begin
                    s_d.phase = PH_IDLE;
                    s_d.busy  = 1'b0;
                    s_d.erase = 1'b0;
                    if (s_q.op_erase) begin
                        erase_go = 1'b1;
                    end else begin
                        prog_go = 1'b1;
                        s_d.lat = '{default: ERASED};
                    end
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
            default: s_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q     <= '0;
            s_q.lat <= '{default: ERASED};
        end else begin
            s_q <= s_d;
        end
    end

    assign cpu_stall = (s_q.phase == PH_BUSY);
    assign wr_busy   = s_q.busy;
    assign free_flag = s_q.erase;
    assign err_flag  = s_q.err;
endmodule

// File: rtl/fsw_checker.sv
module fsw_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       reg_we,
    input logic [2:0] reg_sel,
    input logic [7:0] reg_wdata,
    input logic       cpu_stall,
    input logic       wr_busy,
    input logic       free_flag,
    input logic       err_flag,
    input logic       armed
);
    logic start_wr;
    assign start_wr = reg_we && reg_sel == 3'd4 && reg_wdata[0] && !wr_busy;

    a_r4_stall_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_stall |-> wr_busy);

    a_r1_err_on_unarmed: assert property (@(posedge clk) disable iff (!rst_n)
        (start_wr && !armed) |=> (err_flag && !wr_busy));

    a_r6_latch_no_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (start_wr && reg_wdata[3] && !reg_wdata[2]) |=> (!cpu_stall && !wr_busy));

    a_r5_free_clear_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cpu_stall) |-> (!free_flag && !wr_busy));

    a_r10_blocked_start: assert property (@(posedge clk) disable iff (!rst_n)
        (start_wr && armed && (!reg_wdata[1] || reg_wdata[4])) |=> !wr_busy);

    a_r4_setup_before_stall: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_busy) |-> !cpu_stall);
endmodule

bind flash_selfwrite_ctrl fsw_checker u_chk (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .cpu_stall(cpu_stall), .wr_busy(wr_busy),
    .free_flag(free_flag), .err_flag(err_flag), .armed(key_armed)
);

// File: tb/flash_selfwrite_ctrl_tb.sv
module flash_selfwrite_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 9;
    localparam int LATCHES = 8;
    localparam int ERASE_CYC = 40;
    localparam int PROG_CYC = 24;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reg_we = 1'b0;
    logic [2:0] reg_sel = '0;
    logic [7:0] reg_wdata = '0;
    logic [ADDR_W-1:0] rd_addr = '0;
    logic [13:0] rd_word;
    logic cpu_stall, wr_busy, free_flag, err_flag;
    int vectors = 0;
    int fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_selfwrite_ctrl #(.ADDR_W(ADDR_W), .LATCHES(LATCHES),
        .ERASE_CYCLES(ERASE_CYC), .PROG_CYCLES(PROG_CYC)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .rd_addr(rd_addr), .rd_word(rd_word),
        .cpu_stall(cpu_stall), .wr_busy(wr_busy), .free_flag(free_flag),
        .err_flag(err_flag));

    task automatic chk(input string req, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wreg(input logic [2:0] sel, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
        @(posedge clk); #1;
        reg_we = 1'b0;
    endtask

    task automatic set_ad(input int a, input int d);
        wreg(3'd0, a[7:0]); wreg(3'd1, a[15:8]);
        wreg(3'd2, d[7:0]); wreg(3'd3, {2'b00, d[13:8]});
    endtask

    task automatic rd(input int a, input int exp, input string req);
        rd_addr = a[ADDR_W-1:0]; #1;
        chk(req, rd_word, exp);
    endtask

    task automatic unlock();
        wreg(3'd5, 8'h55); wreg(3'd5, 8'hAA);
    endtask

    // unlocked start that must go through setup and a stall of cyc cycles (R4)
    task automatic run_op(input logic [7:0] ctrl, input int cyc, input string req);
        int n;
        unlock();
        wreg(3'd4, ctrl);
        chk({req, " R4 busy at accept"}, wr_busy, 1);
        chk({req, " R4 setup 1"}, cpu_stall, 0);
        @(posedge clk); #1;
        chk({req, " R4 setup 2"}, cpu_stall, 0);
        @(posedge clk); #1;
        chk({req, " R4 stall start"}, cpu_stall, 1);
        if (ctrl[2]) chk("R5 free during erase", free_flag, 1);
        n = 0;
        while (cpu_stall && n < 100000) begin
            n++;
            @(posedge clk); #1;
        end
        chk({req, " R4 stall length"}, n, cyc);
        chk({req, " R4 busy self-clear"}, wr_busy, 0);
    endtask

    task automatic t_reset();
        chk("R11 stall", cpu_stall, 0);
        chk("R11 busy", wr_busy, 0);
        chk("R11 free", free_flag, 0);
        chk("R2 err reset", err_flag, 0);
        rd(0, 14'h3FFF, "R11 word0");
        rd(511, 14'h3FFF, "R11 last word");
    endtask

    task automatic t_bad_key();
        wreg(3'd5, 8'h55); wreg(3'd0, 8'h00); wreg(3'd5, 8'hAA);
        wreg(3'd4, 8'h03);
        chk("R1 err after interrupted key", err_flag, 1);
        chk("R1 no busy", wr_busy, 0);
        @(posedge clk); #1; @(posedge clk); #1; @(posedge clk); #1;
        chk("R1 no stall", cpu_stall, 0);
        wreg(3'd5, 8'h55); wreg(3'd5, 8'h12); wreg(3'd5, 8'hAA);
        wreg(3'd4, 8'h03);
        chk("R1 err after wrong key", err_flag, 1);
        chk("R1 no busy wrong key", wr_busy, 0);
    endtask

    task automatic t_program();
        set_ad(24, 14'h0001);
        run_op(8'h03, PROG_CYC, "R7 single");
        chk("R2 err cleared", err_flag, 0);
        rd(24, 14'h0001, "R7 row3 word");
        set_ad(16, 14'h1234);
        unlock(); wreg(3'd4, 8'h0B);
        chk("R6 no busy", wr_busy, 0);
        chk("R6 no stall", cpu_stall, 0);
        rd(16, 14'h3FFF, "R6 array untouched");
        set_ad(18, 14'h0ABC);
        unlock(); wreg(3'd4, 8'h0B);
        set_ad(23, 14'h0055);
        run_op(8'h03, PROG_CYC, "R7 block");
        rd(16, 14'h1234, "R7 word16");
        rd(17, 14'h3FFF, "R7 unloaded 17");
        rd(18, 14'h0ABC, "R7 word18");
        rd(23, 14'h0055, "R7 final latch");
        rd(15, 14'h3FFF, "R7 prev row");
        rd(24, 14'h0001, "R7 next row");
    endtask

    task automatic t_and();
        set_ad(18, 14'h0F0F);
        run_op(8'h03, PROG_CYC, "R9");
        rd(18, 14'h0A0C, "R9 and result");
        rd(16, 14'h1234, "R9 other word");
    endtask

    task automatic t_erase();
        set_ad(21, 0);
        run_op(8'h07, ERASE_CYC, "R3");
        chk("R5 free cleared", free_flag, 0);
        rd(16, 14'h3FFF, "R3 word16");
        rd(18, 14'h3FFF, "R3 word18");
        rd(23, 14'h3FFF, "R3 word23");
        rd(24, 14'h0001, "R3 next row kept");
    endtask

    task automatic t_latch_reset();
        set_ad(23, 14'h3FFF);
        run_op(8'h03, PROG_CYC, "R8");
        rd(16, 14'h3FFF, "R8 latch16 reset");
        rd(18, 14'h3FFF, "R8 latch18 reset");
    endtask

    task automatic t_blocked();
        set_ad(24, 0);
        unlock(); wreg(3'd4, 8'h01);
        chk("R10 no busy when disabled", wr_busy, 0);
        @(posedge clk); #1; @(posedge clk); #1; @(posedge clk); #1;
        chk("R10 no stall when disabled", cpu_stall, 0);
        rd(24, 14'h0001, "R10 disabled word kept");
        unlock(); wreg(3'd4, 8'h13);
        chk("R10 no busy alt space", wr_busy, 0);
        @(posedge clk); #1; @(posedge clk); #1; @(posedge clk); #1;
        chk("R10 no stall alt space", cpu_stall, 0);
        rd(24, 14'h0001, "R10 alt word kept");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_bad_key();
        t_program();
        t_and();
        t_erase();
        t_latch_reset();
        t_blocked();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        vectors++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule